// File: doc/BRIEF.md
# Ultra DMA Data-Out Burst Sender

This block is the host side of a data-out burst on a 16-bit parallel disk interface. The device requests a burst on `dmarq`. The block then acknowledges on `dmack_n` and releases `stop`. Once the device signals readiness on `dmardy_n`, the block streams data words on `dout`. It marks each word with one transition of `strobe`, and both rising and falling transitions count. A 3-bit mode input chooses one of five timing sets. The block latches this mode when it accepts a request. Every interval is converted to whole clock cycles at elaboration from the `CLK_NS` parameter, with all fractions rounded up.

Words arrive from a valid/ready source. A word is taken on a clock edge where `word_valid` and `word_ready` are both high. The source must hold `word_data` and `word_last` steady while `word_valid` is high and no transfer has happened. `word_ready` is high only inside a burst, when the output register is empty and the hold time after the previous strobe edge has passed. The word that carries `word_last` closes the burst.

The burst can end in two ways. The source can present its last word, or the device can drop `dmarq`. In both cases the block waits out the quiet time after its last edge, asserts `stop`, and waits for the device to release `dmarq`. It then releases `dmack_n`.

Top module: `udma_out_sender`

## Requirements
- R1: Reset drives `dmack_n`=1, `stop`=1, `strobe`=1 and `word_ready`=0, whatever `dmarq` and the source do during reset.
- R2: `dmack_n` changes only while `stop` is high. `dmack_n` falls no earlier than ceil(20 ns / clock) cycles after `dmarq` rises.
- R3: After `dmack_n` falls, `stop` falls no sooner than ceil(20 ns / clock) cycles and no later than floor(70 ns / clock) cycles for modes 0–2, or floor(55 ns / clock) cycles for modes 3 and 4.
- R4: `strobe` does not toggle before `dmardy_n` has been low (asserted). It never toggles on a clock edge after a cycle in which `dmardy_n` was sampled high. At most one transition is observed after the pin goes high.
- R5: Consecutive `strobe` transitions are at least H cycles apart. H is the largest of three values: ceil(min edge spacing), ceil(half the nominal two-edge period), and ceil(setup)+ceil(6 ns). Min edge spacing is 112/73/54/39/25 ns and the nominal two-edge period is 240/160/120/90/60 ns for modes 0–4. At 4 ns this gives H = 30/20/15/12/8. Mode values 5–7 behave as mode 4.
- R6: `dout` is stable for at least ceil(setup) cycles before each transition it is marked by. Setup is 70/48/30/20/6 ns for modes 0–4.
- R7: `dout` does not change within ceil(6 ns / clock) cycles after a `strobe` transition.
- R8: Every word accepted while `dmarq` stays high is sent exactly once, in acceptance order, one word per transition. `word_ready` is low whenever `dmack_n` is high.
- R9: After the transition carrying the `word_last` word, no further transitions occur. `stop` rises no earlier than ceil(50 ns / clock) cycles after that transition.
- R10: `dmack_n` rises only after `dmarq` has been sampled low. It also rises no earlier than ceil(T / clock) cycles after `stop` rose, where T is 160/125/100/100/100 ns for modes 0–4.
- R11: If `dmarq` falls during a burst, transitions stop at once and the block takes the same stop sequence. A word already loaded but not yet marked is dropped.
- R12: `strobe` toggles only while `dmack_n` is low and `stop` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Timing set 0–4; latched at burst start, 5–7 act as 4 |
| dmarq | input | 1 | Device burst request, active high |
| dmardy_n | input | 1 | Device ready, active low |
| dmack_n | output | 1 | Host acknowledge, active low |
| stop | output | 1 | Host stop request, active high |
| strobe | output | 1 | Data strobe, one word per transition, rests high |
| dout | output | 16 | Data word on the bus |
| word_valid | input | 1 | Source has a word |
| word_data | input | 16 | Source word |
| word_last | input | 1 | Source word is the final one of the burst |
| word_ready | output | 1 | Block takes the word this cycle if valid |

## Verification
Some rules are checked by assertions on every cycle:
- `strobe` toggles only inside the acknowledged, unstopped window.
- `strobe` freezes the cycle after `dmardy_n` is seen high.
- `dmack_n` moves only under an asserted `stop`.
- `dout` stays put in the cycle after a transition, and `stop` never rises together with one.
- `word_ready` stays low outside a burst.

Other rules need measurements across a whole burst, so only the bench scenarios can show them:
- the per-mode edge spacing and data setup;
- the envelope and quiet-time windows around `stop`;
- the hold of `dmack_n` after `stop`;
- the order and count of delivered words, including the loss of a pending word when `dmarq` drops mid-burst.

// File: rtl/udma_out_pkg.sv
package udma_out_pkg;

  typedef enum logic [3:0] {
    IDLE, ACK_SETUP, ENVELOPE, WAIT_READY, STREAM,
    PAUSE, TERM_WAIT, STOP_ASSERT, RELEASE
  } burst_st_e;

  // Fixed intervals shared by every mode, in ns.
  localparam int ACK_NS   = 20;
  localparam int ENV_NS   = 20;
  localparam int HOLD_NS  = 6;
  localparam int QUIET_NS = 50;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int edge_min_ns(input int m);
    case (m)
      0: return 112;
      1: return 73;
      2: return 54;
      3: return 39;
      default: return 25;
    endcase
  endfunction

  function automatic int pair_typ_ns(input int m);
    case (m)
      0: return 240;
      1: return 160;
      2: return 120;
      3: return 90;
      default: return 60;
    endcase
  endfunction

  function automatic int setup_ns(input int m);
    case (m)
      0: return 70;
      1: return 48;
      2: return 30;
      3: return 20;
      default: return 6;
    endcase
  endfunction

  function automatic int stop_hold_ns(input int m);
    case (m)
      0: return 160;
      1: return 125;
      default: return 100;
    endcase
  endfunction

  function automatic int half_cyc(input int m, input int clk_ns);
    int a, b, c;
    a = ns2cyc(edge_min_ns(m), clk_ns);
    b = ns2cyc(pair_typ_ns(m) / 2, clk_ns);
    c = ns2cyc(setup_ns(m), clk_ns) + ns2cyc(HOLD_NS, clk_ns);
    if (b > a) a = b;
    if (c > a) a = c;
    return a;
  endfunction

endpackage

// File: rtl/udma_out_timer.sv
module udma_out_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/udma_out_timing.sv
module udma_out_timing
  import udma_out_pkg::*;
#(
  parameter int CLK_NS = 4,
  parameter int CNT_W  = 8,
  parameter int MODE_W = 3
) (
  input  logic [MODE_W-1:0] mode,
  output logic [CNT_W-1:0]  half_c,
  output logic [CNT_W-1:0]  setup_c,
  output logic [CNT_W-1:0]  stop_hold_c
);
  localparam int NMODES = 5;

  logic [CNT_W-1:0] half_tab  [NMODES];
  logic [CNT_W-1:0] setup_tab [NMODES];
  logic [CNT_W-1:0] shold_tab [NMODES];

  for (genvar m = 0; m < NMODES; m++) begin : g_mode
    localparam int HALF  = half_cyc(m, CLK_NS);
    localparam int SETUP = ns2cyc(setup_ns(m), CLK_NS);
    localparam int SHOLD = ns2cyc(stop_hold_ns(m), CLK_NS);
    assign half_tab[m]  = CNT_W'(HALF);
    assign setup_tab[m] = CNT_W'(SETUP);
    assign shold_tab[m] = CNT_W'(SHOLD);
  end

  logic [MODE_W-1:0] sel;
  always_comb begin
    sel = (mode > MODE_W'(NMODES - 1)) ? MODE_W'(NMODES - 1) : mode;
    half_c      = half_tab[sel];
    setup_c     = setup_tab[sel];
    stop_hold_c = shold_tab[sel];
  end
endmodule

// File: rtl/udma_out_pacer.sv
module udma_out_pacer #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              en_load,
  input  logic              en_edge,
  input  logic [CNT_W-1:0]  hold_c,
  input  logic [CNT_W-1:0]  half_c,
  input  logic [CNT_W-1:0]  setup_c,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_last,
  output logic              src_ready,
  output logic [DATA_W-1:0] dout,
  output logic              strobe,
  output logic              fire,
  output logic              fire_last,
  output logic [CNT_W-1:0]  gap
);
  localparam logic [CNT_W-1:0] SAT = '1;

  logic             pend_q, last_q;
  logic [CNT_W-1:0] gap_q, stab_q;
  logic             load;

  assign src_ready = en_load && !pend_q && (gap_q >= hold_c);
  assign load      = src_ready && src_valid;
  assign fire      = en_edge && pend_q && (gap_q >= half_c) && (stab_q >= setup_c);
  assign fire_last = fire && last_q;
  assign gap       = gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      last_q <= 1'b0;
      dout   <= '0;
      strobe <= 1'b1;
      gap_q  <= SAT;
      stab_q <= '0;
    end else if (start) begin
      pend_q <= 1'b0;
      gap_q  <= SAT;
      stab_q <= '0;
    end else begin
      if (load) begin
        dout   <= src_data;
        last_q <= src_last;
        pend_q <= 1'b1;
        stab_q <= CNT_W'(1);
      end else begin
        if (fire) pend_q <= 1'b0;
        if (stab_q != SAT) stab_q <= stab_q + 1'b1;
      end
      if (fire) begin
        strobe <= ~strobe;
        gap_q  <= CNT_W'(1);
      end else if (gap_q != SAT) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/udma_out_sender.sv
module udma_out_sender
  import udma_out_pkg::*;
#(
  parameter int CLK_NS = 4,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              dmarq,
  input  logic              dmardy_n,
  output logic              dmack_n,
  output logic              stop,
  output logic              strobe,
  output logic [DATA_W-1:0] dout,
  input  logic              word_valid,
  input  logic [DATA_W-1:0] word_data,
  input  logic              word_last,
  output logic              word_ready
);
  localparam int ACK_C   = ns2cyc(ACK_NS, CLK_NS);
  localparam int ENV_C   = ns2cyc(ENV_NS, CLK_NS);
  localparam int HOLD_C  = ns2cyc(HOLD_NS, CLK_NS);
  localparam int QUIET_C = ns2cyc(QUIET_NS, CLK_NS);

  burst_st_e         st_q, st_d;
  logic [MODE_W-1:0] mode_q;
  logic              tload, tdone;
  logic [CNT_W-1:0]  tval;
  logic [CNT_W-1:0]  half_c, setup_c, shold_c, gap;
  logic              fire, fire_last, start, en_load, en_edge, quiet;

  udma_out_timing #(.CLK_NS(CLK_NS), .CNT_W(CNT_W), .MODE_W(MODE_W)) timing_i (
    .mode(mode_q), .half_c(half_c), .setup_c(setup_c), .stop_hold_c(shold_c)
  );

  udma_out_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(tload), .val(tval), .done(tdone)
  );

  assign start   = (st_q == ENVELOPE) && tdone;
  assign en_load = dmarq && (st_q == WAIT_READY || st_q == STREAM || st_q == PAUSE);
  assign en_edge = dmarq && !dmardy_n && (st_q == STREAM);
  assign quiet   = (gap >= CNT_W'(QUIET_C));

  udma_out_pacer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) pacer_i (
    .clk(clk), .rst_n(rst_n), .start(start), .en_load(en_load), .en_edge(en_edge),
    .hold_c(CNT_W'(HOLD_C)), .half_c(half_c), .setup_c(setup_c),
    .src_valid(word_valid), .src_data(word_data), .src_last(word_last),
    .src_ready(word_ready), .dout(dout), .strobe(strobe),
    .fire(fire), .fire_last(fire_last), .gap(gap)
  );

  // Next state and interval loads; the timer reaches zero tval+1 edges after load.
  always_comb begin
    st_d  = st_q;
    tload = 1'b0;
    tval  = '0;
    case (st_q)
      IDLE: if (dmarq) begin
        st_d = ACK_SETUP; tload = 1'b1; tval = CNT_W'(ACK_C - 1);
      end
      ACK_SETUP: if (tdone) begin
        st_d = ENVELOPE; tload = 1'b1; tval = CNT_W'(ENV_C - 1);
      end
      ENVELOPE: if (tdone) st_d = WAIT_READY;
      WAIT_READY: begin
        if (!dmarq)         st_d = TERM_WAIT;
        else if (!dmardy_n) st_d = STREAM;
      end
      STREAM: begin
        if (!dmarq || fire_last) st_d = TERM_WAIT;
        else if (dmardy_n)       st_d = PAUSE;
      end
      PAUSE: begin
        if (!dmarq)         st_d = TERM_WAIT;
        else if (!dmardy_n) st_d = STREAM;
      end
      TERM_WAIT: if (quiet) begin
        st_d = STOP_ASSERT; tload = 1'b1; tval = shold_c - 1'b1;
      end
      STOP_ASSERT: if (tdone && !dmarq) begin
        st_d = RELEASE; tload = 1'b1; tval = CNT_W'(ACK_C - 1);
      end
      RELEASE: if (tdone) st_d = IDLE;
      default: st_d = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= IDLE;
      mode_q  <= '0;
      dmack_n <= 1'b1;
      stop    <= 1'b1;
    end else begin
      st_q <= st_d;
      if (st_q == IDLE && dmarq)      mode_q  <= mode;
      if (st_q == ACK_SETUP && tdone) dmack_n <= 1'b0;
      if (st_q == RELEASE && tdone)   dmack_n <= 1'b1;
      if (start)                      stop    <= 1'b0;
      if (st_q == TERM_WAIT && quiet) stop    <= 1'b1;
    end
  end
endmodule

// File: rtl/udma_out_sender_chk.sv
module udma_out_sender_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dmardy_n,
  input logic              dmack_n,
  input logic              stop,
  input logic              strobe,
  input logic [DATA_W-1:0] dout,
  input logic              word_ready
);
  // R12
  edge_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(strobe) |-> (!dmack_n && !stop));

  // R4
  ready_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmardy_n |=> $stable(strobe));

  // R2
  ack_under_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dmack_n) |-> stop);

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(strobe) |=> $stable(dout));

  // R9
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop) |-> $stable(strobe));

  // R8
  ready_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> !dmack_n);
endmodule

bind udma_out_sender udma_out_sender_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .dmardy_n(dmardy_n), .dmack_n(dmack_n),
  .stop(stop), .strobe(strobe), .dout(dout), .word_ready(word_ready)
);

// File: tb/udma_out_sender_tb_top.sv
module udma_out_sender_tb_top;
  localparam int CLK_NS = 4;

  typedef struct packed {
    logic [2:0] mode;
    logic [7:0] n;
    logic [7:0] pause_at;
    logic [7:0] rdy_del;
    logic [7:0] dq_hold;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'd6,  8'd3, 8'd4,  8'd3},
    '{3'd1, 8'd8,  8'd0, 8'd10, 8'd3},
    '{3'd2, 8'd10, 8'd5, 8'd2,  8'd60},
    '{3'd3, 8'd12, 8'd4, 8'd6,  8'd3},
    '{3'd4, 8'd16, 8'd8, 8'd1,  8'd3},
    '{3'd4, 8'd1,  8'd0, 8'd3,  8'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [2:0]  mode_in = '0;
  logic        dmarq = 1'b0, dmardy_n = 1'b1;
  logic        dmack_n, stop, strobe, word_ready;
  logic [15:0] dout;
  logic        word_valid, word_last;
  logic [15:0] word_data;

  logic        src_on = 1'b0, src_rst = 1'b1;
  logic [7:0]  src_tag = '0;
  logic [15:0] src_n = '0, src_idx;

  assign word_valid = src_on && (src_idx < src_n);
  assign word_data  = {src_tag, src_idx[7:0]};
  assign word_last  = (src_idx == src_n - 16'd1);

  always @(posedge clk) begin
    if (src_rst) src_idx <= '0;
    else if (word_valid && word_ready) src_idx <= src_idx + 16'd1;
  end

  udma_out_sender dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode_in), .dmarq(dmarq), .dmardy_n(dmardy_n),
    .dmack_n(dmack_n), .stop(stop), .strobe(strobe), .dout(dout),
    .word_valid(word_valid), .word_data(word_data), .word_last(word_last),
    .word_ready(word_ready)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int cy(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int setup_exp(input int m);
    case (m) 0: return cy(70); 1: return cy(48); 2: return cy(30); 3: return cy(20); default: return cy(6); endcase
  endfunction

  function automatic int half_exp(input int m);
    int a, b, c;
    case (m)
      0: begin a = cy(112); b = cy(120); end
      1: begin a = cy(73);  b = cy(80);  end
      2: begin a = cy(54);  b = cy(60);  end
      3: begin a = cy(39);  b = cy(45);  end
      default: begin a = cy(25); b = cy(30); end
    endcase
    c = setup_exp(m) + cy(6);
    if (b > a) a = b;
    if (c > a) a = c;
    return a;
  endfunction

  function automatic int envmax_exp(input int m);
    return (m < 3) ? 70 / CLK_NS : 55 / CLK_NS;
  endfunction

  function automatic int rp_exp(input int m);
    case (m) 0: return cy(160); 1: return cy(125); default: return cy(100); endcase
  endfunction

  // Monitor state, sampled at the falling edge.
  int cyc = 0, last_edge = 0, last_dout = 0;
  int t_rq_rise = 0, t_rq_fall = 0, t_ack_fall = 0, t_stop_rise = 0;
  int bedges = 0, rx_idx = 0, since_nr = 0, cur_mode = 0;
  logic [7:0]  cur_tag = '0;
  logic        p_strobe = 1'b1, p_dmack = 1'b1, p_stop = 1'b1, p_rq = 1'b0, p_rdy = 1'b1;
  logic [15:0] p_dout = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (dmarq && !p_rq) t_rq_rise = cyc;
      if (!dmarq && p_rq) t_rq_fall = cyc;
      if (dmardy_n && !p_rdy) since_nr = 0;
      if (strobe !== p_strobe) begin
        chk(!dmack_n && !stop, "R12 edge inside ack window", {dmack_n, stop}, 0);
        if (bedges == 0) chk(!dmardy_n, "R4 first edge after ready", dmardy_n, 0);
        if (dmardy_n) begin
          since_nr++;
          chk(since_nr <= 1, "R4 edges after ready negation", since_nr, 1);
        end
        if (bedges > 0)
          chk(cyc - last_edge >= half_exp(cur_mode), "R5 edge spacing", cyc - last_edge, half_exp(cur_mode));
        chk(cyc - last_dout >= setup_exp(cur_mode), "R6 data setup", cyc - last_dout, setup_exp(cur_mode));
        chk(dout == {cur_tag, 8'(rx_idx)}, "R8 word order", dout, {cur_tag, 8'(rx_idx)});
        rx_idx++;
        bedges++;
        last_edge = cyc;
      end
      if (dout !== p_dout) begin
        if (bedges > 0) chk(cyc - last_edge >= cy(6), "R7 data hold", cyc - last_edge, cy(6));
        last_dout = cyc;
      end
      if (!dmack_n && p_dmack) begin
        t_ack_fall = cyc;
        chk(stop, "R2 stop high at ack", stop, 1);
        chk(cyc - t_rq_rise >= cy(20), "R2 ack setup", cyc - t_rq_rise, cy(20));
      end
      if (!stop && p_stop) begin
        chk(cyc - t_ack_fall >= cy(20), "R3 envelope min", cyc - t_ack_fall, cy(20));
        chk(cyc - t_ack_fall <= envmax_exp(cur_mode), "R3 envelope max", cyc - t_ack_fall, envmax_exp(cur_mode));
      end
      if (stop && !p_stop) begin
        t_stop_rise = cyc;
        if (bedges > 0) chk(cyc - last_edge >= cy(50), "R9 quiet before stop", cyc - last_edge, cy(50));
      end
      if (dmack_n && !p_dmack) begin
        chk(cyc - t_stop_rise >= rp_exp(cur_mode), "R10 stop hold", cyc - t_stop_rise, rp_exp(cur_mode));
        chk(!dmarq && t_rq_fall < cyc, "R10 request released first", dmarq, 0);
      end
      p_strobe = strobe; p_dout = dout; p_dmack = dmack_n; p_stop = stop;
      p_rq = dmarq; p_rdy = dmardy_n;
    end
  end

  task automatic tick(input int k);
    for (int i = 0; i < k; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic begin_burst(input int tag, input int m, input int n);
    tick(1);
    mode_in = 3'(m); cur_mode = m; cur_tag = 8'(tag); src_tag = 8'(tag);
    src_n = 16'(n); src_rst = 1'b1;
    tick(1);
    src_rst = 1'b0; src_on = 1'b1;
    rx_idx = 0; bedges = 0; since_nr = 0;
    dmarq = 1'b1;
    while (dmack_n || stop) tick(1);
  endtask

  task automatic run_burst(input int tag, input vec_t v);
    begin_burst(tag, int'(v.mode), int'(v.n));
    tick(int'(v.rdy_del));
    dmardy_n = 1'b0;
    if (v.pause_at != 0) begin
      while (bedges < int'(v.pause_at)) tick(1);
      dmardy_n = 1'b1;
      tick(15);
      dmardy_n = 1'b0;
    end
    while (!stop) tick(1);
    tick(int'(v.dq_hold));
    dmarq = 1'b0;
    while (!dmack_n) tick(1);
    dmardy_n = 1'b1;
    tick(2);
    chk(rx_idx == int'(v.n), "R8 words delivered", rx_idx, int'(v.n));
    chk(!word_ready, "R8 ready low after burst", word_ready, 0);
    src_on = 1'b0;
  endtask

  initial begin
    // R1: reset state with request and source active.
    dmarq = 1'b1; src_on = 1'b1; src_n = 16'd4; src_rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(dmack_n, "R1 dmack_n reset", dmack_n, 1);
    chk(stop, "R1 stop reset", stop, 1);
    chk(strobe, "R1 strobe reset", strobe, 1);
    chk(!word_ready, "R1 word_ready reset", word_ready, 0);
    dmarq = 1'b0; src_on = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    tick(3);
    @(negedge clk);
    chk(dmack_n && stop && strobe, "R1 idle after reset", {dmack_n, stop, strobe}, 7);

    for (int i = 0; i < NV; i++) run_burst(i + 1, VECS[i]);

    // R11: request withdrawn mid-burst.
    begin_burst(9, 4, 100);
    tick(2);
    dmardy_n = 1'b0;
    while (bedges < 5) tick(1);
    dmarq = 1'b0;
    while (!dmack_n) tick(1);
    dmardy_n = 1'b1;
    tick(2);
    chk(rx_idx == 5, "R11 edges after request drop", rx_idx, 5);
    chk(!word_ready, "R11 ready low after drop", word_ready, 0);
    chk(stop, "R11 stop held after drop", stop, 1);
    src_on = 1'b0;

    // R2/R5: out-of-range mode behaves as mode 4.
    cur_mode = 4;
    begin_burst(10, 7, 4);
    cur_mode = 4;
    tick(1);
    dmardy_n = 1'b0;
    while (!stop) tick(1);
    tick(3);
    dmarq = 1'b0;
    while (!dmack_n) tick(1);
    dmardy_n = 1'b1;
    tick(2);
    chk(rx_idx == 4, "R5 mode 7 delivers", rx_idx, 4);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements): actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule